// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block is a timeout monitor for a serial-bus slave. It counts clock cycles toward a fixed limit. Every acknowledge that the slave drives on the bus restarts the count, and that includes an acknowledge given to a dummy command sent only to keep the timer alive. If the limit is reached with no acknowledge, the block raises a one-cycle timeout request. A separate reset controller turns that request into a timed reset pulse.

The watchdog does not time the reset pulse itself. It watches two conditions. The first is a status line from the reset controller that is high for the whole reset stretch. That stretch may come from power-up, from an external reset input, or from the watchdog's own request. The second is a supply-good flag. While either condition holds, the count is pinned at zero and acknowledges are ignored. When both conditions clear, counting starts again from zero with no host action.

After a timeout the counter stays saturated and raises no second request until the reset status has been seen active and then released. This prevents a stream of repeated requests while the reset controller is slow to respond.

Top module: `bus_ack_watchdog`

## Requirements
- R1: While `rst_n` is low, `wd_bite` is 0 and the count is zero, so the first timeout after reset release needs a full period.
- R2: With no hold and no kick, `wd_bite` goes high for exactly one cycle, on the TIMEOUT_CYC-th rising edge after the last restart point.
- R3: A cycle with `ack_kick` high, outside a hold and before a timeout, restarts the count. The next timeout comes TIMEOUT_CYC edges after that cycle.
- R4: While `rst_active` is 1, the count is held at zero, `wd_bite` stays 0 and `ack_kick` has no effect. Counting starts from zero on the first edge at which `rst_active` is 0.
- R5: While `supply_ok` is 0, the block behaves as in R4.
- R6: After a timeout, no further `wd_bite` is raised and `ack_kick` is ignored until a hold (R4 or R5) has been seen.
- R7: Once the hold that follows a timeout has released, counting resumes from zero without any kick, and the next timeout comes TIMEOUT_CYC edges later.
- R8: A hold that arrives on the edge where the limit would be reached wins, and no timeout is raised.
- R9: A kick that arrives on the edge where the limit would be reached wins, and no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ack_kick | input | 1 | One-cycle strobe for each acknowledge the slave issues |
| rst_active | input | 1 | High while the reset controller is stretching a reset |
| supply_ok | input | 1 | High while the monitored supply is above its trip point |
| wd_bite | output | 1 | One-cycle timeout request to the reset controller |

## Verification
The assertions assume that `ack_kick`, `rst_active` and `supply_ok` are already synchronous to `clk`, and that a single acknowledge shows up as one cycle of `ack_kick`. They do not assume the reset controller answers a timeout at any particular time, so the counter may sit saturated for as long as the stretch is absent. The stimulus changes every input only on the falling clock edge. It mixes random kick rates, including none at all, with random hold episodes driven from either status line. It also includes long periods with no hold after a timeout, so that the saturated state is exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Run: counting toward the limit. Spent: limit reached, waiting for a hold.
  typedef enum logic {
    WD_RUN   = 1'b0,
    WD_SPENT = 1'b1
  } wd_state_e;

endpackage

// File: rtl/wdt_hold_gate.sv
module wdt_hold_gate (
  input  logic rst_active,
  input  logic supply_ok,
  output logic hold
);

  // Any reset stretch or low supply pins the timer.
  always_comb begin
    hold = rst_active | ~supply_ok;
  end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int unsigned TIMEOUT_CYC = 400_000_000,
  localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_en,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (inc_en && (cnt_q != LIMIT_V)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    cnt     = cnt_q;
    at_last = (cnt_q == LAST_V);
  end

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic kick,
  input  logic at_last,
  output logic clr,
  output logic inc_en,
  output logic spent,
  output logic bite
);

  wd_state_e state_q;
  wd_state_e state_d;
  logic      bite_q;
  logic      bite_d;

  always_comb begin
    state_d = state_q;
    bite_d  = 1'b0;
    clr     = 1'b0;
    inc_en  = 1'b0;
    if (hold) begin
      // A hold ends any spent period and pins the count.
      state_d = WD_RUN;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        WD_RUN: begin
          if (kick) begin
            clr = 1'b1;
          end else begin
            inc_en = 1'b1;
            if (at_last) begin
              state_d = WD_SPENT;
              bite_d  = 1'b1;
            end
          end
        end
        WD_SPENT: begin
          // Saturated: kicks are ignored until a hold is seen.
        end
        default: state_d = WD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_RUN;
      bite_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bite_q  <= bite_d;
    end
  end

  always_comb begin
    spent = (state_q == WD_SPENT);
    bite  = bite_q;
  end

endmodule

// File: rtl/bus_ack_watchdog.sv
module bus_ack_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_kick,
  input  logic rst_active,
  input  logic supply_ok,
  output logic wd_bite
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic             hold;
  logic             clr;
  logic             inc_en;
  logic             at_last;
  logic             spent;
  logic [CNT_W-1:0] cnt_q;

  wdt_hold_gate u_hold (
    .rst_active (rst_active),
    .supply_ok  (supply_ok),
    .hold       (hold)
  );

  wdt_tick_counter #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .inc_en  (inc_en),
    .cnt     (cnt_q),
    .at_last (at_last)
  );

  wdt_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .kick    (ack_kick),
    .at_last (at_last),
    .clr     (clr),
    .inc_en  (inc_en),
    .spent   (spent),
    .bite    (wd_bite)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned TIMEOUT_CYC = 400_000_000,
  localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_kick,
  input logic             rst_active,
  input logic             supply_ok,
  input logic             wd_bite,
  input logic [CNT_W-1:0] cnt,
  input logic             spent
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |=> !wd_bite);

  p_bite_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |-> (cnt == LIMIT_V));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT_V);

  p_kick_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_kick && !spent) |=> (cnt == '0 && !wd_bite));

  p_hold_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (cnt == '0 && !wd_bite));

  p_supply_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (cnt == '0 && !wd_bite));

  p_spent_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spent && supply_ok && !rst_active) |=> ($stable(cnt) && !wd_bite && spent));

  p_free_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!spent && supply_ok && !rst_active && !ack_kick && cnt != LIMIT_V)
      |=> (cnt == $past(cnt) + ONE_V));

endmodule

bind bus_ack_watchdog wdt_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_kick   (ack_kick),
  .rst_active (rst_active),
  .supply_ok  (supply_ok),
  .wd_bite    (wd_bite),
  .cnt        (cnt_q),
  .spent      (spent)
);

// File: tb/sim_bus_ack_watchdog.sv
`timescale 1ns/1ps
module sim_bus_ack_watchdog;

  localparam int unsigned L = 24;

  logic clk;
  logic rst_n;
  logic ack_kick;
  logic rst_active;
  logic supply_ok;
  logic wd_bite;

  int n_cmp;
  int n_bad;
  int cyc;
  bit done;
  string cur_req;

  // Reference state, built from the requirements.
  int  m_cnt;
  bit  m_spent;
  bit  m_bite;

  bus_ack_watchdog #(.TIMEOUT_CYC(L)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_kick   (ack_kick),
    .rst_active (rst_active),
    .supply_ok  (supply_ok),
    .wd_bite    (wd_bite)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit is_held(bit ra, bit ok);
    return ra || !ok;
  endfunction

  function automatic bit limit_hit(int cnt_after);
    return cnt_after == L;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_spent = 0; m_bite = 0;
    end else begin
      m_bite = 0;
      if (is_held(rst_active, supply_ok)) begin
        m_cnt = 0; m_spent = 0;
      end else if (!m_spent) begin
        if (ack_kick) m_cnt = 0;
        else begin
          m_cnt = m_cnt + 1;
          if (limit_hit(m_cnt)) begin m_bite = 1; m_spent = 1; end
        end
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: wd_bite actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(cur_req, wd_bite, m_bite);
  endtask

  task automatic quiet(int n, output int bites);
    bites = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (wd_bite) bites++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin
    int b;
    int hold_left;
    int pct;
    bit use_supply;
    n_cmp = 0; n_bad = 0; cyc = 0; done = 0;
    void'($urandom(32'd1234));
    rst_n = 0; ack_kick = 0; rst_active = 0; supply_ok = 1;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", wd_bite, 1'b0);
    rst_n = 1;

    // R1/R2: full period from reset release, one-cycle pulse.
    cur_req = "R2";
    quiet(L - 1, b);
    chk("R1", wd_bite, 1'b0);
    tick();
    chk("R2", wd_bite, 1'b1);
    tick();
    chk("R2", wd_bite, 1'b0);

    // R6: spent, kicks ignored, no new request.
    cur_req = "R6";
    for (int i = 0; i < 3 * L; i++) begin
      ack_kick = (i % 5 == 0);
      tick();
      if (wd_bite) b = 99;
    end
    ack_kick = 0;
    chk("R6", wd_bite, 1'b0);

    // R7: stretch then automatic restart.
    cur_req = "R7";
    rst_active = 1; quiet(5, b); rst_active = 0;
    quiet(L - 1, b);
    chk("R7", (b != 0), 1'b0);
    tick();
    chk("R7", wd_bite, 1'b1);

    // R4: kicks during stretch have no effect, count from zero on release.
    cur_req = "R4";
    rst_active = 1;
    for (int i = 0; i < 3 * L; i++) begin ack_kick = i[0]; tick(); end
    ack_kick = 0; rst_active = 0;
    quiet(L - 1, b);
    chk("R4", (b != 0), 1'b0);
    tick();
    chk("R4", wd_bite, 1'b1);

    // R5: low supply holds the same way.
    cur_req = "R5";
    supply_ok = 0; quiet(2 * L, b);
    chk("R5", (b != 0), 1'b0);
    supply_ok = 1;
    quiet(L - 1, b);
    tick();
    chk("R5", wd_bite, 1'b1);

    // R3: kick restarts the period.
    cur_req = "R3";
    rst_active = 1; tick(); rst_active = 0;
    quiet(L - 3, b);
    ack_kick = 1; tick(); ack_kick = 0;
    quiet(L - 1, b);
    chk("R3", (b != 0), 1'b0);
    tick();
    chk("R3", wd_bite, 1'b1);

    // R9: kick on the limit edge wins.
    cur_req = "R9";
    rst_active = 1; tick(); rst_active = 0;
    quiet(L - 1, b);
    ack_kick = 1; tick(); ack_kick = 0;
    chk("R9", wd_bite, 1'b0);
    quiet(L, b);
    chk("R9", wd_bite, 1'b1);

    // R8: hold on the limit edge wins.
    cur_req = "R8";
    rst_active = 1; tick(); rst_active = 0;
    quiet(L - 1, b);
    supply_ok = 0; tick(); supply_ok = 1;
    chk("R8", wd_bite, 1'b0);
    quiet(L, b);
    chk("R8", wd_bite, 1'b1);

    // Random mix of kick rates and hold episodes against the reference.
    cur_req = "R3";
    hold_left = 0; use_supply = 0;
    for (int blk = 0; blk < 8; blk++) begin
      case (blk % 4)
        0: pct = 1;
        1: pct = 4;
        2: pct = 10;
        default: pct = 0;
      endcase
      for (int i = 0; i < 500; i++) begin
        ack_kick = (($urandom % 100) < pct);
        if (hold_left > 0) begin
          hold_left--;
        end else if (($urandom % 100) < 1) begin
          hold_left = 1 + ($urandom % 10);
          use_supply = $urandom % 2;
        end
        rst_active = (hold_left > 0) && !use_supply;
        supply_ok  = !((hold_left > 0) && use_supply);
        tick();
      end
    end
    ack_kick = 0; rst_active = 0; supply_ok = 1;
    tick();
    finish_run();
  end

endmodule